// File: doc/BRIEF.md
# Four-Lane Parallel Histogram Calculator

This block counts how often each intensity value occurs in a frame. Pixels arrive four at a time in one packed input word, qualified by a valid strobe. Each of the four pixel fields feeds its own lane. A lane has a private count memory with one entry per intensity value. The pixel value addresses that memory directly, and the addressed entry is read, incremented and written back. Every lane can take a new pixel on every clock.

After a fixed number of words (one frame, set by the row, column and bits-per-pixel parameters), the block stops accepting input. It then walks through all bins from zero upward, one bin per clock. In each of those clocks it adds the four partial counts for the bin and presents the total together with the bin index and a valid strobe. Each entry is cleared as it is read, so the next frame can start as soon as the last bin leaves, with no separate clear pass. A one-cycle done pulse marks the last bin.

Top module: `hist4_calc`

## Requirements
- R1: For an input word, the field at bits [k*BPP +: BPP] (k = 0..3) is one pixel. Each of the four fields adds exactly one to the bin equal to its value.
- R2: A word is counted only in a cycle where in_valid and in_ready are both high. Data presented with in_valid low changes no count.
- R3: A pixel value that repeats on consecutive accepted words in the same lane is counted exactly. Every repetition adds one.
- R4: A count of up to ROWS*COLS fits without overflow. A frame in which every pixel has the same value reports ROWS*COLS for that bin, and no bin value ever exceeds ROWS*COLS.
- R5: After ROWS*COLS/4 accepted words, in_ready is low until the done cycle. Words offered while in_ready is low are ignored.
- R6: The merge phase presents every bin exactly once, in ascending order starting at 0, one per clock, with out_valid high. out_count is the sum of the four lanes' counts for that bin.
- R7: done is high for exactly one cycle, coinciding with the output of the last bin (index 2^BPP-1). It is never high without out_valid.
- R8: Every count is zero when the merge phase ends, so consecutive frames are counted independently.
- R9: When words arrive on consecutive clocks, done is high in the cycle that begins ROWS*COLS/4 + 2^BPP rising edges after the edge that accepts the first word.
- R10: out_count reads 0 whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word qualifier |
| in_ready | output | 1 | High while the block accepts pixels (accumulation phase) |
| in_pix | input | 4*BPP | Four packed pixels; lane 0 in the least significant field |
| out_valid | output | 1 | High while out_bin/out_count carry a merged bin |
| out_bin | output | BPP | Index of the bin being presented |
| out_count | output | $clog2(ROWS*COLS)+1 | Merged count of that bin |
| done | output | 1 | One-cycle pulse with the last bin |

## Verification
The assertions assume that the frame size divides evenly into four-pixel words. They also assume that the only way to enter the merge phase is through the word counter, so an accumulation write-back is never in flight when a bin is cleared. The stimulus keeps to this by sending whole frames only. It holds in_valid low with random data between some words. During merging it either offers random words or idles, and it drops in_valid in the done cycle so that no stray word starts the next frame. Frames include a single repeated value, repeated pairs per lane and random data, which exercise the back-to-back forwarding path.

// File: rtl/hist4_pkg.sv
package hist4_pkg;
    typedef enum logic [1:0] {
        PH_ACCUM = 2'd0,
        PH_DRAIN = 2'd1,
        PH_MERGE = 2'd2
    } phase_e;
endpackage

// File: rtl/hist4_lane.sv
module hist4_lane #(
    parameter int BPP = 4,
    parameter int CW  = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_en,
    input  logic [BPP-1:0] acc_pix,
    input  logic           mrg_en,
    input  logic [BPP-1:0] mrg_addr,
    output logic [CW-1:0]  rd_cnt
);
    localparam int NB = 1 << BPP;

    typedef struct packed {
        logic [CW-1:0]  rd;
        logic           stb_v;
        logic [BPP-1:0] stb_addr;
        logic           lw_v;
        logic [BPP-1:0] lw_addr;
        logic [CW-1:0]  lw_val;
    } lane_s;

    lane_s          r_d, r_q;
    logic [CW-1:0]  mem_q [NB];
    logic [CW-1:0]  base;
    logic [CW-1:0]  inc;
    logic [BPP-1:0] raddr;

    always_comb begin
        // forward the previous write-back when it targets the same entry
        base  = (r_q.lw_v && (r_q.lw_addr == r_q.stb_addr)) ? r_q.lw_val : r_q.rd;
        inc   = base + CW'(1);
        raddr = mrg_en ? mrg_addr : acc_pix;

        r_d          = r_q;
        r_d.rd       = (acc_en || mrg_en) ? mem_q[raddr] : r_q.rd;
        r_d.stb_v    = acc_en;
        r_d.stb_addr = acc_pix;
        r_d.lw_v     = r_q.stb_v;
        r_d.lw_addr  = r_q.stb_addr;
        r_d.lw_val   = inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (r_q.stb_v) begin
                mem_q[r_q.stb_addr] <= inc;
            end
            if (mrg_en) begin
                mem_q[mrg_addr] <= '0;
            end
        end
    end

    assign rd_cnt = r_q.rd;

    AST_NO_WRITE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.stb_v && mrg_en));  // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.stb_v |-> (base != '1));  // R4
endmodule

// File: rtl/hist4_ctrl.sv
module hist4_ctrl
    import hist4_pkg::*;
#(
    parameter int BPP   = 4,
    parameter int WORDS = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    output logic           acc_en,
    output logic           mrg_en,
    output logic [BPP-1:0] mrg_addr,
    output logic           out_valid,
    output logic [BPP-1:0] out_bin,
    output logic           done
);
    localparam int WCW = $clog2(WORDS + 1);
    localparam int NB  = 1 << BPP;

    typedef struct packed {
        phase_e         phase;
        logic [WCW-1:0] wcnt;
        logic [BPP-1:0] bin;
        logic           ov;
        logic [BPP-1:0] obin;
        logic           dn;
    } ctrl_s;

    ctrl_s c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.ov   = 1'b0;
        c_d.dn   = 1'b0;
        acc_en   = 1'b0;
        mrg_en   = 1'b0;
        mrg_addr = c_q.bin;
        case (c_q.phase)
            PH_ACCUM: begin
                acc_en = in_valid;
                if (in_valid) begin
                    if (c_q.wcnt == WCW'(WORDS - 1)) begin
                        c_d.wcnt  = '0;
                        c_d.phase = PH_DRAIN;
                    end else begin
                        c_d.wcnt = c_q.wcnt + WCW'(1);
                    end
                end
            end
            PH_DRAIN: begin
                c_d.bin   = '0;
                c_d.phase = PH_MERGE;
            end
            PH_MERGE: begin
                mrg_en   = 1'b1;
                c_d.ov   = 1'b1;
                c_d.obin = c_q.bin;
                if (c_q.bin == BPP'(NB - 1)) begin
                    c_d.dn    = 1'b1;
                    c_d.bin   = '0;
                    c_d.phase = PH_ACCUM;
                end else begin
                    c_d.bin = c_q.bin + BPP'(1);
                end
            end
            default: c_d.phase = PH_ACCUM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.phase <= PH_ACCUM;
        end else begin
            c_q <= c_d;
        end
    end

    assign in_ready  = (c_q.phase == PH_ACCUM);
    assign out_valid = c_q.ov;
    assign out_bin   = c_q.obin;
    assign done      = c_q.dn;

    AST_FIRST_BIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_bin == '0));  // R6
    AST_BIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !$past(done)) |-> (out_bin == $past(out_bin) + BPP'(1)));  // R6
    AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && (out_bin == BPP'(NB - 1))));  // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R7
    AST_NO_ACCEPT_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !done) |-> !in_ready);  // R5
endmodule

// File: rtl/hist4_calc.sv
module hist4_calc #(
    parameter int BPP  = 4,
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int PIXELS = ROWS * COLS,
    localparam int CW     = $clog2(PIXELS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [4*BPP-1:0] in_pix,
    output logic             out_valid,
    output logic [BPP-1:0]   out_bin,
    output logic [CW-1:0]    out_count,
    output logic             done
);
    localparam int LANES = 4;
    localparam int WORDS = PIXELS / LANES;

    logic           acc_en;
    logic           mrg_en;
    logic [BPP-1:0] mrg_addr;
    logic [CW-1:0]  lane_cnt [LANES];
    logic [CW-1:0]  sum;

    hist4_ctrl #(.BPP(BPP), .WORDS(WORDS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .acc_en    (acc_en),
        .mrg_en    (mrg_en),
        .mrg_addr  (mrg_addr),
        .out_valid (out_valid),
        .out_bin   (out_bin),
        .done      (done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hist4_lane #(.BPP(BPP), .CW(CW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_en   (acc_en),
            .acc_pix  (in_pix[g*BPP +: BPP]),
            .mrg_en   (mrg_en),
            .mrg_addr (mrg_addr),
            .rd_cnt   (lane_cnt[g])
        );
    end

    always_comb begin
        sum = '0;
        for (int l = 0; l < LANES; l++) begin
            sum = sum + lane_cnt[l];
        end
    end

    assign out_count = out_valid ? sum : '0;

    // running total of the bins presented in the current merge pass
    logic [CW:0] tot_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tot_q <= '0;
        end else if (done) begin
            tot_q <= '0;
        end else if (out_valid) begin
            tot_q <= tot_q + {1'b0, out_count};
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count <= CW'(PIXELS)));  // R4
    AST_FRAME_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((tot_q + {1'b0, out_count}) == (CW + 1)'(PIXELS)));  // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_count == '0));  // R10
endmodule

// File: tb/hist4_calc_tb.sv
`timescale 1ns/1ps
module hist4_calc_tb;
    localparam int BPP    = 4;
    localparam int ROWS   = 8;
    localparam int COLS   = 8;
    localparam int PIXELS = ROWS * COLS;
    localparam int CW     = $clog2(PIXELS) + 1;
    localparam int WORDS  = PIXELS / 4;
    localparam int NB     = 1 << BPP;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [4*BPP-1:0] in_pix = '0;
    logic             out_valid;
    logic [BPP-1:0]   out_bin;
    logic [CW-1:0]    out_count;
    logic             done;

    int nchk = 0;
    int nerr = 0;
    logic [4*BPP-1:0] frame_w [WORDS];
    int exp_h [NB];

    always #2.5 clk = ~clk;

    hist4_calc #(.BPP(BPP), .ROWS(ROWS), .COLS(COLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .out_valid(out_valid), .out_bin(out_bin),
        .out_count(out_count), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic calc_expected();
        for (int b = 0; b < NB; b++) exp_h[b] = 0;
        for (int w = 0; w < WORDS; w++)
            for (int l = 0; l < 4; l++)
                exp_h[frame_w[w][l*BPP +: BPP]]++;
    endtask

    task automatic reset_check();
        @(negedge clk);
        check(in_ready == 1'b1, "R5", "ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R6", "out_valid after reset", out_valid, 0);
        check(done == 1'b0, "R7", "done after reset", done, 0);
        check(out_count == '0, "R10", "count after reset", out_count, 0);
    endtask

    // gaps: idle words with random data between some words; junk: offer words while merging
    task automatic run_frame(input bit gaps, input bit junk, input string req);
        int t = 0;
        int nout = 0;
        bit seen = 0;
        calc_expected();
        for (int w = 0; w < WORDS; w++) begin
            if (gaps && (w % 3 == 1)) begin
                @(negedge clk);
                t++;
                in_valid = 1'b0;
                in_pix = 16'($urandom);  // R2: must not be counted
            end
            if (w > 0 || gaps) begin
                @(negedge clk);
                t++;
            end else begin
                @(negedge clk);
                t = 0;
            end
            check(in_ready == 1'b1, "R5", "ready while accumulating", in_ready, 1);
            in_valid = 1'b1;
            in_pix = frame_w[w];
        end
        for (int k = 0; k < 200 && !seen; k++) begin
            @(negedge clk);
            t++;
            if (out_valid) begin
                check(out_bin == BPP'(nout), "R6", "bin order", out_bin, nout);
                if (nout < NB)
                    check(out_count == CW'(exp_h[nout]), req, "bin count", out_count, exp_h[nout]);
                if (!done)
                    check(in_ready == 1'b0, "R5", "ready during merge", in_ready, 0);
                else
                    check(nout == NB - 1, "R7", "done on last bin", nout, NB - 1);
                nout++;
            end else begin
                check(out_count == '0, "R10", "count while idle", out_count, 0);
                check(done == 1'b0, "R7", "done without out_valid", done, 0);
            end
            if (done) begin
                seen = 1;
                in_valid = 1'b0;
                if (!gaps)
                    check(t == WORDS + NB + 1, "R9", "latency to done", t, WORDS + NB + 1);
            end else begin
                in_valid = junk;  // R5: words offered during merge are ignored
                in_pix = 16'($urandom);
            end
        end
        check(seen, "R7", "done seen", seen, 1);
        check(nout == NB, "R6", "bins presented", nout, NB);
        @(negedge clk);
        check(done == 1'b0 && out_valid == 1'b0, "R7", "done single pulse", done, 0);
        check(in_ready == 1'b1, "R5", "ready after done", in_ready, 1);
    endtask

    task automatic test_lanes();  // R1: each field counted in its own bin
        for (int w = 0; w < WORDS; w++)
            frame_w[w] = {BPP'(3), BPP'(2), BPP'(1 + (w % 2)), BPP'(w)};
        run_frame(0, 0, "R1");
    endtask

    task automatic test_all_same();  // R3, R4: same value every pixel
        for (int w = 0; w < WORDS; w++)
            frame_w[w] = {4{BPP'(5)}};
        run_frame(0, 1, "R4");
    endtask

    task automatic test_pairs();  // R3: values repeat on pairs of words
        for (int w = 0; w < WORDS; w++)
            frame_w[w] = {BPP'(w / 2), BPP'(9), BPP'(w / 2 + 3), BPP'(15 - w / 4)};
        run_frame(0, 0, "R3");
    endtask

    task automatic test_random_gaps();  // R2, R5
        for (int w = 0; w < WORDS; w++)
            frame_w[w] = 16'($urandom);
        run_frame(1, 1, "R2");
    endtask

    task automatic test_back_to_back();  // R8: fresh counts after previous frame
        for (int w = 0; w < WORDS; w++)
            frame_w[w] = {BPP'(0), BPP'(w), BPP'(NB - 1), BPP'(w * 7)};
        run_frame(0, 0, "R8");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        reset_check();
        test_lanes();
        test_all_same();
        test_pairs();
        test_random_gaps();
        test_back_to_back();
        test_all_same();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule